// File: doc/BRIEF.md
# Two-Stage Memory Port Arbiter

This block decides, on every clock cycle, which of four requesters may use a shared single-ported RAM. The requesters come from two ports, and each port has one read requester and one write requester. The primary port's two requesters go straight to a three-level fixed-priority stage. The secondary port's read and write requesters are first reduced to a single candidate by a round-robin pre-arbiter. That candidate always takes the lowest priority level.

Arbitration works per beat, not per burst. Each requester presents one already-split beat, which is a RAM-wide address and, for writes, a 128-bit data word. A write requester raises its request only when its data is present. A granted write therefore never waits. A static configuration input, `swapPri`, exchanges the primary port's high and medium levels.

Grants are combinational from the requests in the same cycle. The selected beat is registered onto the RAM command outputs at the next rising edge.

Top module: `mpa_arbiter`

## Requirements
- R1: While `rstN` is low and on the first cycle after its release, `ramEn` and `ramWe` are 0. The round-robin pointer restarts in the state that favours the secondary read requester.
- R2: No more than one of the four grants is high in any cycle. A grant is high only if its own request is high. Whenever any request is high, exactly one grant is high.
- R3: With `swapPri` = 0, the order is primary write (highest), then primary read, then the secondary port's pre-arbitrated winner (lowest).
- R4: With `swapPri` = 1, the order is primary read (highest), then primary write, then the secondary port's pre-arbitrated winner (lowest).
- R5: When both secondary requesters are held high and the secondary port keeps winning, the grants alternate read, write, read and so on. The first grant after reset goes to read.
- R6: The round-robin pointer changes only in a cycle where a secondary grant is issued. A cycle in which the secondary port loses to the primary port leaves its preference unchanged.
- R7: A lone secondary requester wins the low level whatever the pointer state. After a secondary grant, the pointer favours the other secondary requester.
- R8: Rising edge N+1 loads the beat granted in cycle N onto the RAM outputs:
  - `ramEn` = 1.
  - `ramWe` = 1 for a write grant and 0 for a read grant.
  - `ramAddr` takes the granted requester's address.
  - `ramWdata` takes the granted write data, or all zeros for a read.
- R9: A cycle without any grant loads `ramEn` = 0 and `ramWe` = 0 at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| swapPri | input | 1 | 0: primary write above primary read; 1: reversed |
| priRdReq | input | 1 | Primary read beat request |
| priRdAddr | input | ADDR_W | Primary read beat address |
| priWrReq | input | 1 | Primary write beat request (data valid) |
| priWrAddr | input | ADDR_W | Primary write beat address |
| priWrData | input | DATA_W | Primary write beat data |
| secRdReq | input | 1 | Secondary read beat request |
| secRdAddr | input | ADDR_W | Secondary read beat address |
| secWrReq | input | 1 | Secondary write beat request (data valid) |
| secWrAddr | input | ADDR_W | Secondary write beat address |
| secWrData | input | DATA_W | Secondary write beat data |
| priRdGnt | output | 1 | Primary read granted this cycle |
| priWrGnt | output | 1 | Primary write granted this cycle |
| secRdGnt | output | 1 | Secondary read granted this cycle |
| secWrGnt | output | 1 | Secondary write granted this cycle |
| ramEn | output | 1 | RAM access enable |
| ramWe | output | 1 | RAM write enable |
| ramAddr | output | ADDR_W | RAM address |
| ramWdata | output | DATA_W | RAM write data |

## Verification
Grants depend only on the current requests and the pointer, so they are due in the same cycle as the request. The bench changes inputs at the falling edge and compares grants one time unit later. A beat granted in cycle N is due on the RAM outputs after the rising edge that ends cycle N. The behavioural model queues that beat and compares it at the next falling edge. A pointer update made at that same rising edge first shows up in the following cycle's grants, and the model updates its own preference at that point.

// File: rtl/mpa_pkg.sv
package mpa_pkg;

  localparam int unsigned SRC_NUM = 4;
  localparam int unsigned SRC_W   = $clog2(SRC_NUM);
  localparam int unsigned LVL_NUM = 3;

  typedef enum logic [SRC_W-1:0] {
    SRC_PRI_RD = 2'd0,
    SRC_PRI_WR = 2'd1,
    SRC_SEC_RD = 2'd2,
    SRC_SEC_WR = 2'd3
  } src_e;

  typedef struct packed {
    logic issue;
    src_e srcSel;
  } mpa_strobe_t;

endpackage

// File: rtl/mpa_ctrl.sv
module mpa_ctrl
  import mpa_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        swapPri,
  input  logic        priRdReq,
  input  logic        priWrReq,
  input  logic        secRdReq,
  input  logic        secWrReq,
  output logic        priRdGnt,
  output logic        priWrGnt,
  output logic        secRdGnt,
  output logic        secWrGnt,
  output mpa_strobe_t strobe
);

  // Round-robin stage: bit0 = read, bit1 = write
  logic       rrPtr;        // 0: favour read, 1: favour write
  logic [1:0] rrGnt;
  logic       loReq;

  always_comb begin
    rrGnt = 2'b00;
    if (secRdReq && secWrReq) begin
      rrGnt = rrPtr ? 2'b10 : 2'b01;
    end else begin
      rrGnt = {secWrReq, secRdReq};
    end
  end
  assign loReq = |rrGnt;

  // Fixed-priority stage: bit2 = high, bit1 = medium, bit0 = low
  logic [LVL_NUM-1:0] lvlReq;
  logic [LVL_NUM-1:0] fixGnt;

  assign lvlReq = swapPri ? {priRdReq, priWrReq, loReq}
                          : {priWrReq, priRdReq, loReq};

  always_comb begin
    fixGnt = '0;
    for (int i = LVL_NUM-1; i >= 0; i--) begin
      if (lvlReq[i] && (fixGnt == '0)) begin
        fixGnt[i] = 1'b1;
      end
    end
  end

  always_comb begin
    priWrGnt = swapPri ? fixGnt[1] : fixGnt[2];
    priRdGnt = swapPri ? fixGnt[2] : fixGnt[1];
    secRdGnt = fixGnt[0] & rrGnt[0];
    secWrGnt = fixGnt[0] & rrGnt[1];
  end

  // Pointer advances only when the low level is actually granted
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rrPtr <= 1'b0;
    end else if (fixGnt[0]) begin
      rrPtr <= rrGnt[0];
    end
  end

  always_comb begin
    strobe.issue  = |fixGnt;
    strobe.srcSel = SRC_PRI_RD;
    if (priWrGnt)      strobe.srcSel = SRC_PRI_WR;
    else if (secRdGnt) strobe.srcSel = SRC_SEC_RD;
    else if (secWrGnt) strobe.srcSel = SRC_SEC_WR;
  end

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({priRdGnt, priWrGnt, secRdGnt, secWrGnt})) else $error("multiple grants"); // R2
  AST_GNT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    ((priRdGnt -> priRdReq) && (priWrGnt -> priWrReq) &&
     (secRdGnt -> secRdReq) && (secWrGnt -> secWrReq))) else $error("grant without request"); // R2
  AST_WORK_CONSERVE: assert property (@(posedge clk) disable iff (!rstN)
    (priRdReq || priWrReq || secRdReq || secWrReq) |->
    $countones({priRdGnt, priWrGnt, secRdGnt, secWrGnt}) == 1) else $error("idle with request"); // R2
  AST_ORDER_DEFAULT: assert property (@(posedge clk) disable iff (!rstN)
    (!swapPri && priWrReq) |-> priWrGnt) else $error("default order broken"); // R3
  AST_ORDER_SWAPPED: assert property (@(posedge clk) disable iff (!rstN)
    (swapPri && priRdReq) |-> priRdGnt) else $error("swapped order broken"); // R4
  AST_RR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(secRdGnt || secWrGnt) |=> $stable(rrPtr)) else $error("pointer moved"); // R6
  AST_RR_AFTER_RD: assert property (@(posedge clk) disable iff (!rstN)
    secRdGnt |=> rrPtr) else $error("pointer not on write"); // R7
  AST_RR_AFTER_WR: assert property (@(posedge clk) disable iff (!rstN)
    secWrGnt |=> !rrPtr) else $error("pointer not on read"); // R5

endmodule

// File: rtl/mpa_datapath.sv
module mpa_datapath
  import mpa_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  mpa_strobe_t       strobe,
  input  logic [ADDR_W-1:0] priRdAddr,
  input  logic [ADDR_W-1:0] priWrAddr,
  input  logic [DATA_W-1:0] priWrData,
  input  logic [ADDR_W-1:0] secRdAddr,
  input  logic [ADDR_W-1:0] secWrAddr,
  input  logic [DATA_W-1:0] secWrData,
  output logic              ramEn,
  output logic              ramWe,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [DATA_W-1:0] ramWdata
);

  logic [ADDR_W-1:0] srcAddr [SRC_NUM];
  logic [DATA_W-1:0] srcData [SRC_NUM];
  logic [SRC_NUM-1:0] srcIsWr;

  assign srcAddr[SRC_PRI_RD] = priRdAddr;
  assign srcAddr[SRC_PRI_WR] = priWrAddr;
  assign srcAddr[SRC_SEC_RD] = secRdAddr;
  assign srcAddr[SRC_SEC_WR] = secWrAddr;
  assign srcData[SRC_PRI_RD] = '0;
  assign srcData[SRC_PRI_WR] = priWrData;
  assign srcData[SRC_SEC_RD] = '0;
  assign srcData[SRC_SEC_WR] = secWrData;

  for (genvar s = 0; s < SRC_NUM; s++) begin : g_kind
    assign srcIsWr[s] = (s == SRC_PRI_WR) || (s == SRC_SEC_WR);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ramEn    <= 1'b0;
      ramWe    <= 1'b0;
      ramAddr  <= '0;
      ramWdata <= '0;
    end else begin
      ramEn <= strobe.issue;
      ramWe <= strobe.issue && srcIsWr[strobe.srcSel];
      if (strobe.issue) begin
        ramAddr  <= srcAddr[strobe.srcSel];
        ramWdata <= srcData[strobe.srcSel];
      end
    end
  end

  AST_ISSUE_TO_RAM: assert property (@(posedge clk) disable iff (!rstN)
    strobe.issue |=> ramEn) else $error("granted beat lost"); // R8
  AST_IDLE_NO_RAM: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.issue |=> !ramEn && !ramWe) else $error("spurious RAM access"); // R9
  AST_WE_IMPLIES_EN: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> ramEn) else $error("write without enable"); // R8

endmodule

// File: rtl/mpa_arbiter.sv
module mpa_arbiter
  import mpa_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              swapPri,
  input  logic              priRdReq,
  input  logic [ADDR_W-1:0] priRdAddr,
  input  logic              priWrReq,
  input  logic [ADDR_W-1:0] priWrAddr,
  input  logic [DATA_W-1:0] priWrData,
  input  logic              secRdReq,
  input  logic [ADDR_W-1:0] secRdAddr,
  input  logic              secWrReq,
  input  logic [ADDR_W-1:0] secWrAddr,
  input  logic [DATA_W-1:0] secWrData,
  output logic              priRdGnt,
  output logic              priWrGnt,
  output logic              secRdGnt,
  output logic              secWrGnt,
  output logic              ramEn,
  output logic              ramWe,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [DATA_W-1:0] ramWdata
);

  mpa_strobe_t strobe;

  mpa_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .swapPri  (swapPri),
    .priRdReq (priRdReq),
    .priWrReq (priWrReq),
    .secRdReq (secRdReq),
    .secWrReq (secWrReq),
    .priRdGnt (priRdGnt),
    .priWrGnt (priWrGnt),
    .secRdGnt (secRdGnt),
    .secWrGnt (secWrGnt),
    .strobe   (strobe)
  );

  mpa_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .priRdAddr (priRdAddr),
    .priWrAddr (priWrAddr),
    .priWrData (priWrData),
    .secRdAddr (secRdAddr),
    .secWrAddr (secWrAddr),
    .secWrData (secWrData),
    .ramEn     (ramEn),
    .ramWe     (ramWe),
    .ramAddr   (ramAddr),
    .ramWdata  (ramWdata)
  );

endmodule

// File: tb/mpa_arbiter_tb.sv
module mpa_arbiter_tb;

  localparam int unsigned ADDR_W = 16;
  localparam int unsigned DATA_W = 128;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              swapPri = 1'b0;
  logic              priRdReq = 1'b0, priWrReq = 1'b0, secRdReq = 1'b0, secWrReq = 1'b0;
  logic [ADDR_W-1:0] priRdAddr = 16'h1000, priWrAddr = 16'h2000;
  logic [ADDR_W-1:0] secRdAddr = 16'h3000, secWrAddr = 16'h4000;
  logic [DATA_W-1:0] priWrData = {4{32'hA5A5_0001}}, secWrData = {4{32'h5A5A_0002}};
  logic              priRdGnt, priWrGnt, secRdGnt, secWrGnt;
  logic              ramEn, ramWe;
  logic [ADDR_W-1:0] ramAddr;
  logic [DATA_W-1:0] ramWdata;

  int checks = 0;
  int failures = 0;

  // reference model state
  int                pref = 0;  // 0: secondary read favoured, 1: write
  bit                expEn = 0, expWe = 0;
  logic [ADDR_W-1:0] expAddr = '0;
  logic [DATA_W-1:0] expData = '0;

  always #5 clk = ~clk;

  mpa_arbiter #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rstN(rstN), .swapPri(swapPri),
    .priRdReq(priRdReq), .priRdAddr(priRdAddr),
    .priWrReq(priWrReq), .priWrAddr(priWrAddr), .priWrData(priWrData),
    .secRdReq(secRdReq), .secRdAddr(secRdAddr),
    .secWrReq(secWrReq), .secWrAddr(secWrAddr), .secWrData(secWrData),
    .priRdGnt(priRdGnt), .priWrGnt(priWrGnt), .secRdGnt(secRdGnt), .secWrGnt(secWrGnt),
    .ramEn(ramEn), .ramWe(ramWe), .ramAddr(ramAddr), .ramWdata(ramWdata)
  );

  task automatic check(input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // returns {priRd, priWr, secRd, secWr}
  function automatic logic [3:0] model_grant();
    string order [3];
    if (swapPri) order = '{"PR", "PW", "S"};
    else         order = '{"PW", "PR", "S"};
    foreach (order[k]) begin
      if (order[k] == "PR" && priRdReq) return 4'b1000;
      if (order[k] == "PW" && priWrReq) return 4'b0100;
      if (order[k] == "S") begin
        if (secRdReq && secWrReq) return (pref == 1) ? 4'b0001 : 4'b0010;
        if (secRdReq) return 4'b0010;
        if (secWrReq) return 4'b0001;
      end
    end
    return 4'b0000;
  endfunction

  task automatic step(input logic sw, input logic prd, input logic pwr,
                      input logic srd, input logic swr, input string tag);
    logic [3:0] g;
    swapPri = sw; priRdReq = prd; priWrReq = pwr; secRdReq = srd; secWrReq = swr;
    #1;
    g = model_grant();
    check(tag, {priRdGnt, priWrGnt, secRdGnt, secWrGnt}, g);
    check("R8/R9 ram", {ramEn, ramWe}, {expEn, expWe});
    if (expEn) check("R8 ramAddr/ramWdata", {ramAddr, ramWdata}, {expAddr, expData});
    @(posedge clk);
    expEn = (g != 4'b0000);
    expWe = g[2] || g[0];
    case (g)
      4'b1000: begin expAddr = priRdAddr; expData = '0; end
      4'b0100: begin expAddr = priWrAddr; expData = priWrData; end
      4'b0010: begin expAddr = secRdAddr; expData = '0; pref = 1; end
      4'b0001: begin expAddr = secWrAddr; expData = secWrData; pref = 0; end
      default: ;
    endcase
    @(negedge clk);
  endtask

  initial begin : watchdog
    #1500000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset ram", {ramEn, ramWe}, 2'b00);
    rstN = 1'b1;
    step(0, 0, 0, 0, 0, "R2 idle");               // R1 first cycle outputs idle
    step(0, 0, 0, 0, 0, "R2 idle");
    step(0, 1, 1, 1, 1, "R3 all requesters default");
    step(0, 1, 0, 1, 1, "R3 primary read over secondary");
    step(1, 1, 1, 1, 1, "R4 all requesters swapped");
    step(1, 0, 1, 1, 1, "R4 primary write over secondary");
    // R1/R5: first secondary grant after reset is read, then alternate
    for (int i = 0; i < 6; i++) step(0, 0, 0, 1, 1, "R5 alternation");
    // R6: secondary blocked, preference must hold
    step(0, 0, 0, 1, 1, "R5 read turn");
    for (int i = 0; i < 3; i++) step(0, 1, 0, 1, 1, "R6 blocked");
    step(0, 0, 0, 1, 1, "R6 write still favoured");
    // R7: lone requester regardless of pointer
    step(0, 0, 0, 1, 0, "R7 lone read");
    step(0, 0, 0, 1, 0, "R7 lone read again");
    step(0, 0, 0, 1, 1, "R7 write after read");
    step(0, 0, 0, 0, 1, "R7 lone write");
    step(0, 0, 0, 1, 1, "R7 read after write");
    step(0, 0, 0, 0, 0, "R9 idle after grant");
    for (int i = 0; i < 400; i++) begin
      priRdAddr = ADDR_W'($urandom);
      priWrAddr = ADDR_W'($urandom);
      secRdAddr = ADDR_W'($urandom);
      secWrAddr = ADDR_W'($urandom);
      priWrData = {$urandom, $urandom, $urandom, $urandom};
      secWrData = {$urandom, $urandom, $urandom, $urandom};
      step(($urandom % 8) == 0, ($urandom % 4) == 0, ($urandom % 4) == 0,
           ($urandom % 2) == 0, ($urandom % 2) == 0, "R2 random mix");
    end
    step(0, 0, 0, 0, 0, "R9 final idle");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule